// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It owns the command pins while the memory is being brought up, and it keeps the memory refreshed after that. After reset it keeps clock-enable and the data mask high and issues no-operation commands for a programmable stable period. It then precharges every bank and issues a programmable number of auto-refresh commands, at least two. It writes the mode register last and then raises a done flag.

After bring-up, an interval counter raises a refresh request at a fixed spacing. This spacing is normally the refresh period divided by the number of rows, rounded down to whole clocks. A request is served only when the block is idle and the read/write side reports it is not using the bus. Each request is served with a precharge-all, a precharge wait, an auto-refresh command and a refresh-cycle wait. Requests that arrive while the bus is in use are counted and are never lost.

All timings are parameters in clock cycles. The package provides helpers that turn nanosecond minimums into cycles by rounding up.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is held, and afterwards, `cke` and `dqm` are 1. After reset is released the command bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111) for exactly WAIT_CYC cycles. The cycle in which reset is released counts as the first of these.
- R2: The next cycle carries precharge-all: command 0010 with `addr[10]` = 1, every other address bit 0 and `ba` = 0.
- R3: After the precharge-all, NOP is held for T_RP-1 cycles. Then INIT_REFS auto-refresh commands (0001, `addr` = 0) are issued, each followed by T_RC-1 NOP cycles.
- R4: The next command is mode register set (0000). `addr[2:0]` holds the burst-length code, `addr[3]` the burst type, `addr[6:4]` the latency code and `addr[9]` the write-burst bit. All other address bits and `ba` are 0.
- R5: Exactly one NOP cycle follows the mode register set. `init_done` rises in the cycle after that NOP and stays high.
- R6: Counting from the first cycle with `init_done` high as d = 0, a refresh request is raised at every d with d mod REF_INT = REF_INT-1. In an idle cycle with a request owed and `host_busy` low, the refresh sequence starts in the next cycle. Otherwise the bus carries NOP and `addr` = 0.
- R7: A refresh sequence is a precharge-all (as in R2), then T_RP-1 NOP cycles, then an auto-refresh, then T_RC-1 NOP cycles. `refresh_busy` is 1 exactly during those cycles.
- R8: A request owed while `host_busy` is high, or while a sequence is running, stays owed until it is served. Each request produces exactly one sequence. Several owed requests are served one after another, with one idle cycle between them.
- R9: Before `init_done`, `host_busy` has no effect on the command sequence and `refresh_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_busy | input | 1 | Read/write side is using the command bus |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (A10 selects all banks on precharge) |
| ba | output | BANK_W | Bank address |
| init_done | output | 1 | Bring-up complete |
| refresh_busy | output | 1 | A refresh sequence owns the bus |

## Verification
The bench builds the block with WAIT_CYC = 25, T_RP = 3, T_RC = 5, INIT_REFS = 3 and REF_INT = 40. It uses a mode word with every programmable field non-zero. With these values the whole bring-up takes 45 cycles, so repeated init refreshes and multi-cycle gaps are both exercised. A 100-cycle busy window spans three refresh requests, so several requests pile up and are then served one after another. Short, scattered busy pulses later on shift individual grants by a cycle.

// File: rtl/sdbs_pkg.sv
package sdbs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT, ST_IPRE, ST_IREF, ST_IMRS, ST_IDLE, ST_RPRE, ST_RREF
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] bus_cmd_t;
  localparam bus_cmd_t CMD_NOP  = 4'b0111;
  localparam bus_cmd_t CMD_PALL = 4'b0010;
  localparam bus_cmd_t CMD_AREF = 4'b0001;
  localparam bus_cmd_t CMD_MRS  = 4'b0000;

  localparam int MRS_GAP = 2;

  // minimum times: round up to whole clocks
  function automatic int ns_to_cycles_up(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  // maximum spacing: round down, never below one clock
  function automatic int ns_to_cycles_down(input int ns, input int period_ns);
    return (ns / period_ns < 1) ? 1 : ns / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // reserved bits stay zero
  function automatic logic [11:0] build_mode(input logic [2:0] bl_code,
                                             input logic bt,
                                             input logic [2:0] cl_code,
                                             input logic wb_single);
    logic [11:0] m;
    m      = '0;
    m[2:0] = bl_code;
    m[3]   = bt;
    m[6:4] = cl_code;
    m[9]   = wb_single;
    return m;
  endfunction

endpackage

// File: rtl/sdbs_step_timer.sv
module sdbs_step_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= CNT_W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R3
endmodule

// File: rtl/sdbs_refresh_clock.sv
module sdbs_refresh_clock #(
  parameter int REF_INT = 781,
  parameter int PEND_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic grant,
  output logic tick,
  output logic owed
);
  localparam int IVL_W = $clog2(REF_INT + 1);

  logic [IVL_W-1:0]  ivl_q;
  logic [PEND_W-1:0] pend_q;
  logic              pend_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ivl_q <= IVL_W'(REF_INT - 1);
    else if (!run)         ivl_q <= IVL_W'(REF_INT - 1);
    else if (ivl_q == '0)  ivl_q <= IVL_W'(REF_INT - 1);
    else                   ivl_q <= ivl_q - 1'b1;
  end

  assign tick = run && (ivl_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else begin
      case ({tick, grant})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign owed      = (pend_q != '0);
  assign pend_full = &pend_q;

  AST_PEND_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && !grant && pend_full)); // R8
  AST_GRANT_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> owed); // R8
endmodule

// File: rtl/sdbs_pin_encoder.sv
module sdbs_pin_encoder
  import sdbs_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          BANK_W = 2,
  parameter logic [11:0] MODE   = 12'h000
) (
  input  seq_state_t        state,
  input  logic              first,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba
);
  bus_cmd_t cmd;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    if (first) begin
      case (state)
        ST_IPRE, ST_RPRE: begin cmd = CMD_PALL; addr[10] = 1'b1; end
        ST_IREF, ST_RREF: cmd = CMD_AREF;
        ST_IMRS: begin cmd = CMD_MRS; addr[11:0] = MODE; end
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba = '0;
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdbs_pkg::*;
#(
  parameter int       CLK_NS    = 20,
  parameter int       ADDR_W    = 12,
  parameter int       BANK_W    = 2,
  parameter int       WAIT_CYC  = ns_to_cycles_up(200000, CLK_NS),
  parameter int       T_RP      = ns_to_cycles_up(20, CLK_NS),
  parameter int       T_RC      = ns_to_cycles_up(70, CLK_NS),
  parameter int       INIT_REFS = 2,
  parameter int       REF_INT   = ns_to_cycles_down(15625, CLK_NS),
  parameter int       PEND_W    = 3,
  parameter logic [2:0] BL_CODE = 3'b011,
  parameter logic     BT_SEL    = 1'b0,
  parameter logic [2:0] CL_CODE = 3'b011,
  parameter logic     WB_SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_busy,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done,
  output logic              refresh_busy
);
  localparam int CNT_W  = $clog2(max2(max2(WAIT_CYC, T_RC), max2(T_RP, MRS_GAP)) + 1);
  localparam int RIDX_W = $clog2(INIT_REFS + 1);
  localparam logic [11:0] MODE_WORD = build_mode(BL_CODE, BT_SEL, CL_CODE, WB_SINGLE);

  seq_state_t        state_q, state_nxt;
  logic              first_q, done_q;
  logic              step_load, expired, grant, tick, owed, last_ref;
  logic [CNT_W-1:0]  load_val;
  logic [RIDX_W-1:0] ref_idx_q;
  logic [3:0]        cmd_bus;

  function automatic int step_len(input seq_state_t s);
    case (s)
      ST_WAIT:          return WAIT_CYC;
      ST_IPRE, ST_RPRE: return T_RP;
      ST_IREF, ST_RREF: return T_RC;
      ST_IMRS:          return MRS_GAP;
      default:          return 1;
    endcase
  endfunction

  assign last_ref = (ref_idx_q == RIDX_W'(INIT_REFS - 1));
  assign grant    = (state_q == ST_IDLE) && owed && !host_busy;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_WAIT: if (expired) state_nxt = ST_IPRE;
      ST_IPRE: if (expired) state_nxt = ST_IREF;
      ST_IREF: if (expired && last_ref) state_nxt = ST_IMRS;
      ST_IMRS: if (expired) state_nxt = ST_IDLE;
      ST_IDLE: if (grant)   state_nxt = ST_RPRE;
      ST_RPRE: if (expired) state_nxt = ST_RREF;
      ST_RREF: if (expired) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign step_load = (state_nxt != state_q) || (state_q == ST_IREF && expired);
  assign load_val  = CNT_W'(step_len(state_nxt) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_WAIT;
      first_q   <= 1'b1;
      done_q    <= 1'b0;
      ref_idx_q <= '0;
    end else begin
      state_q <= state_nxt;
      first_q <= step_load;
      if (state_nxt == ST_IDLE) done_q <= 1'b1;
      if (state_q == ST_IREF && expired)
        ref_idx_q <= last_ref ? '0 : ref_idx_q + 1'b1;
    end
  end

  sdbs_step_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(step_load), .load_val(load_val), .expired(expired)
  );

  sdbs_refresh_clock #(.REF_INT(REF_INT), .PEND_W(PEND_W)) u_refclk (
    .clk(clk), .rst_n(rst_n), .run(done_q), .grant(grant), .tick(tick), .owed(owed)
  );

  sdbs_pin_encoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MODE(MODE_WORD)) u_pins (
    .state(state_q), .first(first_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba)
  );

  assign cke          = 1'b1;
  assign dqm          = 1'b1;
  assign init_done    = done_q;
  assign refresh_busy = (state_q == ST_RPRE) || (state_q == ST_RREF);
  assign cmd_bus      = {cs_n, ras_n, cas_n, we_n};

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R5
  AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bus == CMD_MRS) |=> (cmd_bus == CMD_NOP)); // R5
  AST_MRS_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> ($past(cmd_bus, 2) == CMD_MRS)); // R4
  AST_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_busy); // R9
  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_busy) |-> !$past(host_busy)); // R8
  AST_SEQ_OPENS_PALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_busy) |-> (cmd_bus == CMD_PALL)); // R7
endmodule

// File: tb/test_sdram_bringup_seq.sv
module test_sdram_bringup_seq;
  localparam int WAIT_CYC = 25, T_RP = 3, T_RC = 5, INIT_REFS = 3, REF_INT = 40;
  localparam int NCYC = 600;
  // burst length code 2, interleave, latency code 3, single-write: 0x002+0x008+0x030+0x200
  localparam logic [11:0] EXP_MODE = 12'h23A;

  logic clk = 1'b0, rst_n = 1'b0, host_busy = 1'b1;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, init_done, refresh_busy;
  logic [11:0] addr;
  logic [1:0]  ba;

  int checks = 0, errors = 0;
  logic [3:0]  q_cmd[$];
  logic [11:0] q_addr[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  sdram_bringup_seq #(
    .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RC(T_RC), .INIT_REFS(INIT_REFS),
    .REF_INT(REF_INT), .BL_CODE(3'b010), .BT_SEL(1'b1), .CL_CODE(3'b011), .WB_SINGLE(1'b1)
  ) i_sdram_bringup_seq (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .cke(cke), .dqm(dqm),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .init_done(init_done), .refresh_busy(refresh_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [11:0] a, input string tag,
                      input int nops, input string nop_tag);
    q_cmd.push_back(c); q_addr.push_back(a); q_tag.push_back(tag);
    for (int k = 0; k < nops; k++) begin
      q_cmd.push_back(4'b0111); q_addr.push_back(12'h000); q_tag.push_back(nop_tag);
    end
  endtask

  function automatic logic busy_at(input int j);
    return (j < 50) || (j >= 150 && j < 250) || (j > 300 && j < 450 && (j % 7) == 3);
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic init_over;
    int dstart, owed, ticks, served, max_owed;
    logic [3:0] ecmd; logic [11:0] eaddr; string etag; logic erb, was_idle, tick, grant;
    init_over = 0; dstart = 0; owed = 0; ticks = 0; served = 0; max_owed = 0;

    repeat (3) @(negedge clk);
    chk("R1 reset cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1 reset cke/dqm", {cke, dqm}, 2'b11);
    chk("R5 reset done", init_done, 0);
    chk("R9 reset refresh_busy", refresh_busy, 0);

    for (int k = 0; k < WAIT_CYC; k++) push(4'b0111, 12'h000, "R1 wait NOP", 0, "");
    push(4'b0010, 12'h400, "R2 init precharge-all", T_RP - 1, "R3 tRP gap");
    for (int k = 0; k < INIT_REFS; k++) push(4'b0001, 12'h000, "R3 init refresh", T_RC - 1, "R3 tRC gap");
    push(4'b0000, EXP_MODE, "R4 mode set", 1, "R5 MRS gap");

    rst_n = 1'b1;
    for (int j = 0; j < NCYC; j++) begin
      if (j > 0) @(negedge clk);
      was_idle = (q_cmd.size() == 0);
      if (was_idle) begin
        if (!init_over) begin init_over = 1; dstart = j; end
        ecmd = 4'b0111; eaddr = 12'h000; etag = "R6 idle"; erb = 0;
      end else begin
        ecmd = q_cmd.pop_front(); eaddr = q_addr.pop_front(); etag = q_tag.pop_front();
        erb = init_over;
      end
      chk(etag, {cs_n, ras_n, cas_n, we_n}, ecmd);
      chk(etag, {ba, addr}, {2'b00, eaddr});
      chk("R1 cke/dqm high", {cke, dqm}, 2'b11);
      chk("R5 init_done", init_done, init_over);
      chk(init_over ? "R7 refresh_busy" : "R9 refresh_busy", refresh_busy, erb);

      host_busy = busy_at(j);
      if (init_over) begin
        tick  = (((j - dstart) % REF_INT) == REF_INT - 1);
        grant = was_idle && owed > 0 && !host_busy;
        if (grant) begin
          push(4'b0010, 12'h400, "R7 refresh precharge-all", T_RP - 1, "R7 tRP gap");
          push(4'b0001, 12'h000, "R7 refresh", T_RC - 1, "R7 tRC gap");
          served++;
        end
        if (tick) ticks++;
        owed = owed + (tick ? 1 : 0) - (grant ? 1 : 0);
        if (owed > max_owed) max_owed = owed;
      end
    end
    chk("R8 every request served or owed", ticks, served + owed);
    chk("R8 backlog of several requests reached", (max_owed >= 2) ? 1 : 0, 1);
    chk("R6 requests were raised", (ticks >= 10) ? 1 : 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule